// File: doc/BRIEF.md
# Single-Bus Subroutine-Call Sequencer

This block is a small multicycle processor core in which every register transfer passes over one shared internal bus. It contains a program counter, a memory address latch, a memory data latch, the register-index field of the current instruction, a temporary register that holds the ALU result, and a small file of general-purpose registers. All arithmetic goes through the single ALU, including the program-counter increment. No separate incrementer exists.

Its main instruction is a two-word subroutine call. The first word carries the opcode and a destination register index. The second word carries the target address. Execute writes the return address (the address after the second word) into the chosen register, then jumps to the target. The execute phase takes three cycles, because the return-address increment overlaps the two-cycle memory read of the target word.

A halt opcode stops the sequencer so a test can end. Every other opcode only advances the program counter. Memory is read through an address port and a read strobe; the memory model sits outside the block and returns data combinationally for the presented address. Debug outputs expose the program counter, the register file, the number of execute cycles of the latest instruction, and a halted flag.

The controller has seven states:

| State | What it does | Next state |
|---|---|---|
| `ST_F_ADDR` | PC drives the bus into MAR; the ALU increments into TMP | always `ST_F_READ` |
| `ST_F_READ` | read strobe; MDR captures memory; TMP drives the bus into PC | always `ST_F_DEC` |
| `ST_F_DEC` | MDR drives the bus into the instruction latch; decode | call opcode: `ST_X_ADDR`; halt opcode: `ST_HALT`; any other opcode: `ST_F_ADDR` |
| `ST_X_ADDR` | PC into MAR; the ALU increments into TMP | always `ST_X_LINK` |
| `ST_X_LINK` | read strobe; MDR captures the target; TMP drives the bus into Rn | always `ST_X_JUMP` |
| `ST_X_JUMP` | MDR drives the bus into PC | always `ST_F_ADDR` |
| `ST_HALT` | no activity | stays in `ST_HALT` |

Top module: `sbus_call_cpu`

## Requirements
- R1: After reset, PC, every general-purpose register, the memory address and the execute-cycle count read zero. The read strobe is low, and the sequencer starts in its first fetch cycle.
- R2: A fetch takes three cycles. In the first, PC is copied to the memory address. After the second, PC equals its old value plus one. In the third, the fetched word is latched as the instruction.
- R3: Each memory read uses two cycles. The address is loaded in one cycle, and the read strobe is high for exactly the one following cycle while the address holds steady.
- R4: A call is a word with bits [15:12] equal to 4'h1 and the register index in bits [1:0]. It sets that register to the post-fetch PC plus one.
- R5: After a call, PC equals the memory word at the post-fetch PC (the call's second word).
- R6: A call takes exactly three execute cycles, and the execute-cycle count reads 3 when it ends. A halt or any other opcode leaves the count at 0.
- R7: A word with bits [15:12] equal to 4'hF halts the sequencer. The halted flag rises, PC and registers stay frozen, and no further reads occur.
- R8: A word with any other value in bits [15:12] changes nothing but PC, which advances by one.
- R9: At most one source drives the internal bus in any cycle.
- R10: A call writes no register other than the indexed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | DW | Memory address (memory address latch) |
| mem_rd | output | 1 | Read strobe, high in the data-capture cycle |
| mem_rdata | input | DW | Memory data for `mem_addr` |
| dbg_pc | output | DW | Program counter |
| dbg_regs | output | NREG*DW | General-purpose registers, register i at bits [i*DW +: DW] |
| dbg_exec_cnt | output | 3 | Execute cycles spent by the latest instruction |
| dbg_halted | output | 1 | High once a halt has been decoded |

## Verification
The assertions check on every cycle that at most one bus driver is selected, that the read strobe lasts one cycle over a steady address, that the execute count never passes three, and that a halted core stays halted with a frozen PC and no reads. The bench scenarios show what no cycle-local property can: that the return address and jump target land in the right register and PC for different indices and nested calls, that unknown opcodes only advance PC, and that a reset in the middle of a call clears state that was already written.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int OPW  = 4;
    localparam logic [OPW-1:0] OP_CALL = 4'h1;
    localparam logic [OPW-1:0] OP_HALT = 4'hF;

    localparam int SRC_PC  = 0;
    localparam int SRC_TMP = 1;
    localparam int SRC_MDR = 2;
    localparam int NSRC    = 3;

    localparam int CNTW = 3;

    typedef enum logic [2:0] {
        ST_F_ADDR,
        ST_F_READ,
        ST_F_DEC,
        ST_X_ADDR,
        ST_X_LINK,
        ST_X_JUMP,
        ST_HALT
    } seq_state_t;

    typedef enum logic {
        ALU_PASS,
        ALU_INC
    } alu_op_t;

    typedef struct packed {
        logic [NSRC-1:0] drv;
        logic            ld_mar;
        logic            ld_mdr;
        logic            ld_pc;
        logic            ld_ir;
        logic            ld_tmp;
        logic            ld_rn;
        logic            rd;
        alu_op_t         alu_op;
    } uop_t;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_t       op,
    input  logic [DW-1:0] a,
    output logic [DW-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_PASS: y = a;
            ALU_INC:  y = a + DW'(1);
        endcase
    end

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    parameter int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [RW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] rd_flat
);

    // one register per index; only the addressed one takes the write
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (we && (waddr == RW'(g))) begin
                r_q <= wdata;
            end
        end

        assign rd_flat[g*DW +: DW] = r_q;
    end

endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
    import sbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPW-1:0]   dec_op,
    output seq_state_t       state_q,
    output uop_t             uop,
    output logic [CNTW-1:0]  exec_cnt
);

    seq_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_F_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_F_ADDR: state_d = ST_F_READ;
            ST_F_READ: state_d = ST_F_DEC;
            ST_F_DEC: begin
                if (dec_op == OP_CALL) begin
                    state_d = ST_X_ADDR;
                end else if (dec_op == OP_HALT) begin
                    state_d = ST_HALT;
                end else begin
                    state_d = ST_F_ADDR;
                end
            end
            ST_X_ADDR: state_d = ST_X_LINK;
            ST_X_LINK: state_d = ST_X_JUMP;
            ST_X_JUMP: state_d = ST_F_ADDR;
            ST_HALT:   state_d = ST_HALT;
        endcase
    end

    // micro-operations: one bus driver per state at most
    always_comb begin
        uop        = '0;
        uop.alu_op = ALU_PASS;
        unique case (state_q)
            ST_F_ADDR, ST_X_ADDR: begin
                uop.drv[SRC_PC] = 1'b1;
                uop.ld_mar      = 1'b1;
                uop.alu_op      = ALU_INC;
                uop.ld_tmp      = 1'b1;
            end
            ST_F_READ: begin
                uop.rd           = 1'b1;
                uop.ld_mdr       = 1'b1;
                uop.drv[SRC_TMP] = 1'b1;
                uop.ld_pc        = 1'b1;
            end
            ST_F_DEC: begin
                uop.drv[SRC_MDR] = 1'b1;
                uop.ld_ir        = 1'b1;
            end
            ST_X_LINK: begin
                uop.rd           = 1'b1;
                uop.ld_mdr       = 1'b1;
                uop.drv[SRC_TMP] = 1'b1;
                uop.ld_rn        = 1'b1;
            end
            ST_X_JUMP: begin
                uop.drv[SRC_MDR] = 1'b1;
                uop.ld_pc        = 1'b1;
            end
            ST_HALT: begin
                uop = '0;
            end
        endcase
    end

    // execute-cycle counter: cleared at decode, counts execute states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_cnt <= '0;
        end else if (state_q == ST_F_DEC) begin
            exec_cnt <= '0;
        end else if (state_q == ST_X_ADDR || state_q == ST_X_LINK ||
                     state_q == ST_X_JUMP) begin
            exec_cnt <= exec_cnt + CNTW'(1);
        end
    end

endmodule

// File: rtl/sbus_call_cpu.sv
module sbus_call_cpu
    import sbus_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [DW-1:0]      mem_addr,
    output logic               mem_rd,
    input  logic [DW-1:0]      mem_rdata,
    output logic [DW-1:0]      dbg_pc,
    output logic [NREG*DW-1:0] dbg_regs,
    output logic [CNTW-1:0]    dbg_exec_cnt,
    output logic               dbg_halted
);

    localparam int RW = (NREG > 1) ? $clog2(NREG) : 1;

    seq_state_t      state_q;
    uop_t            uop;
    logic [NSRC-1:0] bus_sel;
    logic [DW-1:0]   bus;
    logic [DW-1:0]   alu_y;
    logic [DW-1:0]   src [NSRC];

    logic [DW-1:0]   pc_q;
    logic [DW-1:0]   mar_q;
    logic [DW-1:0]   mdr_q;
    logic [DW-1:0]   tmp_q;
    logic [RW-1:0]   rn_q;

    sbus_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_op   (bus[DW-1 -: OPW]),
        .state_q  (state_q),
        .uop      (uop),
        .exec_cnt (dbg_exec_cnt)
    );

    assign bus_sel      = uop.drv;
    assign src[SRC_PC]  = pc_q;
    assign src[SRC_TMP] = tmp_q;
    assign src[SRC_MDR] = mdr_q;

    // shared bus: OR of the selected sources
    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (bus_sel[i]) begin
                bus = bus | src[i];
            end
        end
    end

    sbus_alu #(.DW(DW)) u_alu (
        .op (uop.alu_op),
        .a  (bus),
        .y  (alu_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            tmp_q <= '0;
            rn_q  <= '0;
        end else begin
            if (uop.ld_pc)  pc_q  <= bus;
            if (uop.ld_mar) mar_q <= bus;
            if (uop.ld_mdr) mdr_q <= mem_rdata;
            if (uop.ld_tmp) tmp_q <= alu_y;
            if (uop.ld_ir)  rn_q  <= bus[RW-1:0];
        end
    end

    sbus_regfile #(.DW(DW), .NREG(NREG), .RW(RW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (uop.ld_rn),
        .waddr   (rn_q),
        .wdata   (bus),
        .rd_flat (dbg_regs)
    );

    assign mem_addr   = mar_q;
    assign mem_rd     = uop.rd;
    assign dbg_pc     = pc_q;
    assign dbg_halted = (state_q == ST_HALT);

endmodule

// File: rtl/sbus_call_chk.sv
module sbus_call_chk
    import sbus_pkg::*;
#(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] bus_sel,
    input logic            mem_rd,
    input logic [DW-1:0]   mem_addr,
    input logic [DW-1:0]   dbg_pc,
    input logic [CNTW-1:0] dbg_exec_cnt,
    input logic            dbg_halted
);

    // R9
    bus_single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel));

    // R3
    read_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3
    read_addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> $stable(mem_addr));

    // R6
    exec_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exec_cnt <= CNTW'(3));

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halted |=> (dbg_halted && $stable(dbg_pc)));

    // R7
    halt_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halted |-> !mem_rd);

endmodule

bind sbus_call_cpu sbus_call_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .dbg_pc       (dbg_pc),
    .dbg_exec_cnt (dbg_exec_cnt),
    .dbg_halted   (dbg_halted)
);

// File: tb/sbus_call_cpu_bench.sv
module sbus_call_cpu_bench;

    localparam int DW   = 16;
    localparam int NREG = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DW-1:0]     mem_addr;
    logic              mem_rd;
    logic [DW-1:0]     mem_rdata;
    logic [DW-1:0]     dbg_pc;
    logic [NREG*DW-1:0] dbg_regs;
    logic [2:0]        dbg_exec_cnt;
    logic              dbg_halted;

    logic [DW-1:0] mem [0:255];

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    sbus_call_cpu #(.DW(DW), .NREG(NREG)) u_sbus_call_cpu (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_addr     (mem_addr),
        .mem_rd       (mem_rd),
        .mem_rdata    (mem_rdata),
        .dbg_pc       (dbg_pc),
        .dbg_regs     (dbg_regs),
        .dbg_exec_cnt (dbg_exec_cnt),
        .dbg_halted   (dbg_halted)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // behavioural reference: phase number plus architectural values
    int            m_ph;
    int            m_cnt;
    logic [DW-1:0] m_pc, m_addr, m_link, m_word;
    int            m_rn;
    logic [DW-1:0] m_reg [NREG];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dut_reg(input int i);
        return dbg_regs[i*DW +: DW];
    endfunction

    task automatic model_reset();
        m_ph = 0; m_cnt = 0; m_rn = 0;
        m_pc = '0; m_addr = '0; m_link = '0; m_word = '0;
        for (int i = 0; i < NREG; i++) m_reg[i] = '0;
    endtask

    // phases: 0..2 fetch, 3..5 call execute, 6 halted
    task automatic model_step();
        case (m_ph)
            0: begin m_addr = m_pc; m_link = m_pc + 1; m_ph = 1; end
            1: begin m_word = mem[m_addr[7:0]]; m_pc = m_link; m_ph = 2; end
            2: begin
                m_cnt = 0;
                m_rn  = int'(m_word[1:0]);
                if (m_word[15:12] == 4'h1)      m_ph = 3;
                else if (m_word[15:12] == 4'hF) m_ph = 6;
                else                            m_ph = 0;
            end
            3: begin m_addr = m_pc; m_link = m_pc + 1; m_cnt++; m_ph = 4; end
            4: begin m_word = mem[m_addr[7:0]]; m_reg[m_rn] = m_link; m_cnt++; m_ph = 5; end
            5: begin m_pc = m_word; m_cnt++; m_ph = 0; end
            default: m_ph = 6;
        endcase
    endtask

    // R9: a second bus driver would corrupt the PC or register values below
    task automatic compare_all();
        chk("R2", "mem_addr", 32'(mem_addr), 32'(m_addr));
        chk("R3", "mem_rd", 32'(mem_rd), 32'((m_ph == 1) || (m_ph == 4)));
        chk("R5", "pc", 32'(dbg_pc), 32'(m_pc));
        for (int i = 0; i < NREG; i++) chk("R4", "reg", 32'(dut_reg(i)), 32'(m_reg[i]));
        chk("R6", "exec_cnt", 32'(dbg_exec_cnt), 32'(m_cnt));
        chk("R7", "halted", 32'(dbg_halted), 32'(m_ph == 6));
        if (m_ph == 0 && m_cnt == 3) chk("R6", "call exec cycles", 32'(dbg_exec_cnt), 32'd3);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        chk("R1", "reset pc", 32'(dbg_pc), 32'd0);
        chk("R1", "reset addr", 32'(mem_addr), 32'd0);
        chk("R1", "reset rd", 32'(mem_rd), 32'd0);
        chk("R1", "reset regs", 32'(dbg_regs[31:0] | dbg_regs[63:32]), 32'd0);
        chk("R1", "reset cnt", 32'(dbg_exec_cnt), 32'd0);
        compare_all();
        model_step();
    endtask

    task automatic run_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_all();
            model_step();
        end
    endtask

    task automatic run_to_halt(input int limit);
        int k = 0;
        while (m_ph != 6 && k < limit) begin
            run_cycles(1);
            k++;
        end
        run_cycles(6);  // R7: frozen afterwards
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // scenario A: single call into a halt
        clear_mem();
        mem[0]    = 16'h1002;
        mem[1]    = 16'h0010;
        mem[16]   = 16'hF000;
        apply_reset();
        run_to_halt(100);
        chk("R4", "R2 holds return address", 32'(dut_reg(2)), 32'h0002);
        chk("R5", "pc past halt at target", 32'(dbg_pc), 32'h0011);
        chk("R10", "R0 untouched", 32'(dut_reg(0)), 32'h0);
        chk("R10", "R3 untouched", 32'(dut_reg(3)), 32'h0);
        chk("R7", "halted", 32'(dbg_halted), 32'h1);
        chk("R6", "halt leaves zero count", 32'(dbg_exec_cnt), 32'h0);

        // scenario B: no-op, unknown opcode, nested calls
        clear_mem();
        mem[0]  = 16'h0000;
        mem[1]  = 16'h7ABC;
        mem[2]  = 16'h1001;
        mem[3]  = 16'h0020;
        mem[32] = 16'h1003;
        mem[33] = 16'h0030;
        mem[48] = 16'hF000;
        apply_reset();
        run_cycles(6);
        chk("R8", "pc after two plain words", 32'(dbg_pc), 32'h0002);
        chk("R8", "regs unchanged", 32'(dbg_regs), 32'h0);
        chk("R6", "plain word count", 32'(dbg_exec_cnt), 32'h0);
        run_to_halt(200);
        chk("R4", "R1 return", 32'(dut_reg(1)), 32'h0004);
        chk("R4", "R3 return", 32'(dut_reg(3)), 32'h0022);
        chk("R5", "pc after nested", 32'(dbg_pc), 32'h0031);
        chk("R10", "R0 untouched", 32'(dut_reg(0)), 32'h0);

        // scenario C: call writing register 0
        clear_mem();
        mem[0]  = 16'h1000;
        mem[1]  = 16'h0040;
        mem[64] = 16'hF000;
        apply_reset();
        run_to_halt(100);
        chk("R4", "R0 return", 32'(dut_reg(0)), 32'h0002);
        chk("R10", "R1 untouched", 32'(dut_reg(1)), 32'h0);
        chk("R5", "pc", 32'(dbg_pc), 32'h0041);

        // scenario D: reset during a call after the link write
        clear_mem();
        mem[0]  = 16'h1002;
        mem[1]  = 16'h0010;
        mem[16] = 16'hF000;
        apply_reset();
        run_cycles(6);
        chk("R4", "link written before reset", 32'(dut_reg(2)), 32'h0002);
        apply_reset();
        chk("R1", "reg cleared by reset", 32'(dut_reg(2)), 32'h0);
        run_to_halt(100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule